// File: doc/BRIEF.md
# PHY Reset Sequencer

This block orders the reset of a small Ethernet transceiver that runs from a 25 MHz reference clock. Three things can start a reset. The first is a supply-good input that models the power-on threshold. The second is an active-low reset pin, which must stay low for a minimum run of cycles before it counts. The third is a self-clearing reset bit in the management control register.

Whatever the source, the block pulses or holds a strobe that returns the management registers to their defaults. Leaving reset happens in two stages. The management port becomes usable a fixed 16 cycles after release. The data-side interface stays gated until a much longer clock-settling interval has run out.

While the supply-good hold is in progress, the pin is isolated. The control register's reset bit reads back only a software request that is in flight. It never shows a pin or power-on reset. A new qualifying reset that arrives during either exit stage restarts the sequence from the beginning.

Top module: `phy_rst_seq`

## Requirements
- R1: A pin reset is taken only after `rst_pin_n` has been sampled low on at least LOW_MIN (5) consecutive rising edges. Both ready flags drop after edge L+SYNC_STAGES+LOW_MIN-1, where edge L is the first edge that samples the pin low (edge L+6 with the defaults).
- R2: A low pulse on the pin lasting fewer than LOW_MIN edges has no effect on any output.
- R3: Define the release edge as follows. For a pin reset, it is the first edge that samples the pin high again. For a power-on reset, it is POR_DLY edges after the first edge that samples `pwr_good` high. For a software reset, it is the write edge itself. `mgmt_ready` is low after release edges +0 to +15 and high after release edge +16 (MGMT_DLY).
- R4: `data_clk_valid` rises after release edge +CLK_SETTLE (default 1,325,000, which is 53 ms) and is never high while `mgmt_ready` is low.
- R5: After `pwr_good` is seen high, reset is held for POR_DLY cycles (default 500, which is 20 us). The staged exit then runs as in R3 and R4.
- R6: While the power-on hold is in progress, the pin is isolated. A low pulse of any length that ends inside the hold changes no output.
- R7: A write with bit 15 of `ctrl_wdata` set starts a software reset. A write with bit 15 clear has no effect.
- R8: `regs_load` is high after every edge that takes a reset. It stays high through a pin hold, from the trigger edge until release edge +1, and through a power-on hold, until release edge -1. For a software reset it is high for exactly one cycle. It is low otherwise.
- R9: A qualifying pin or software reset that arrives during either exit stage, or in normal run, clears both ready flags at that edge and restarts the timing from the new release.
- R10: `ctrl_rst_rd` reads 1 for exactly the one cycle after an accepted software write. It reads 0 during and after pin and power-on resets.
- R11: A control write made while `mgmt_ready` is low is ignored.
- R12: While `pwr_good` is low, the block is held in power-on reset: both ready flags are low, `regs_load` is high and `ctrl_rst_rd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz reference clock |
| pwr_good | input | 1 | Synchronous supply-good; low forces power-on reset |
| rst_pin_n | input | 1 | Asynchronous active-low reset pin |
| ctrl_wr | input | 1 | Write strobe for the management control register |
| ctrl_wdata | input | CTRL_W | Control write data; bit RST_BIT (15) requests reset |
| ctrl_rst_rd | output | 1 | Read-back value of the self-clearing reset bit |
| regs_load | output | 1 | Load default values into the management registers |
| mgmt_ready | output | 1 | Management port usable |
| data_clk_valid | output | 1 | Transmit/receive clocks valid; data interface enabled |

## Verification
Every result is due a fixed number of edges after its stimulus. The ready flags drop SYNC_STAGES+LOW_MIN-1 edges after a pin goes low. `mgmt_ready` rises 16 edges after release and `data_clk_valid` rises CLK_SETTLE edges after release. `regs_load` and the read-back bit react on the write edge itself. The bench indexes every edge of a scenario from its first stimulus edge and computes the expected value of every output after each edge from these counts. It drives and samples 2 ns after the rising edge. It sweeps pin pulse widths from 1 to 8 cycles and covers restarts during both exit stages as well as writes made while the port is not ready.

// File: rtl/phy_rst_pkg.sv
package phy_rst_pkg;

   typedef enum logic [2:0] {
      IDLE_RUN  = 3'd0,
      POR_HOLD  = 3'd1,
      PIN_HOLD  = 3'd2,
      MGMT_WAIT = 3'd3,
      CLK_WAIT  = 3'd4
   } rst_state_e;

   function automatic int unsigned maxu(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/phy_rst_pin_qual.sv
module phy_rst_pin_qual #(
   parameter int SYNC_STAGES = 2,
   parameter int LOW_MIN     = 5
) (
   input  logic clk,
   input  logic pin_n,
   input  logic isolate,
   output logic pin_high,
   output logic trig
);
   localparam int QW = $clog2(LOW_MIN + 1);
   localparam logic [QW-1:0] LOW_SAT  = QW'(LOW_MIN);
   localparam logic [QW-1:0] LOW_LAST = QW'(LOW_MIN - 1);

   logic [SYNC_STAGES-1:0] chain;
   logic [QW-1:0]          low_cnt;

   genvar gi;
   generate
      for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
         if (gi == 0) begin : g_first
            always_ff @(posedge clk) chain[gi] <= pin_n;
         end else begin : g_next
            always_ff @(posedge clk) chain[gi] <= chain[gi-1];
         end
      end
   endgenerate

   assign pin_high = chain[SYNC_STAGES-1];

   // consecutive-low run length, cleared while isolated
   always_ff @(posedge clk) begin
      if (isolate || pin_high)
         low_cnt <= '0;
      else if (low_cnt != LOW_SAT)
         low_cnt <= low_cnt + 1'b1;
   end

   assign trig = !isolate && !pin_high && (low_cnt == LOW_LAST);

endmodule

// File: rtl/phy_rst_ctrl_bit.sv
module phy_rst_ctrl_bit #(
   parameter int CTRL_W  = 16,
   parameter int RST_BIT = 15
) (
   input  logic              clk,
   input  logic              pwr_good,
   input  logic              wr_allow,
   input  logic              ctrl_wr,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   output logic              sw_go,
   output logic              bit_rd
);
   localparam logic [CTRL_W-1:0] RST_MASK = CTRL_W'(1) << RST_BIT;

   assign sw_go = pwr_good && wr_allow && ctrl_wr && (|(ctrl_wdata & RST_MASK));

   // bit is set by the accepted write, cleared once defaults are loaded
   always_ff @(posedge clk) begin
      if (!pwr_good)
         bit_rd <= 1'b0;
      else
         bit_rd <= sw_go;
   end

endmodule

// File: rtl/phy_rst_seq_fsm.sv
module phy_rst_seq_fsm
   import phy_rst_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int POR_DLY     = 500,
   parameter int MGMT_DLY    = 16,
   parameter int CLK_SETTLE  = 1325000
) (
   input  logic clk,
   input  logic pwr_good,
   input  logic pin_trig,
   input  logic pin_high,
   input  logic sw_go,
   output logic por_hold,
   output logic regs_load,
   output logic mgmt_ready,
   output logic data_clk_valid
);
   localparam int CNT_W = $clog2(maxu(POR_DLY, CLK_SETTLE) + 1);
   localparam logic [CNT_W-1:0] POR_END    = CNT_W'(POR_DLY);
   localparam logic [CNT_W-1:0] MGMT_END   = CNT_W'(MGMT_DLY - 1);
   localparam logic [CNT_W-1:0] CLK_END    = CNT_W'(CLK_SETTLE - MGMT_DLY - 1);
   localparam logic [CNT_W-1:0] PIN_CREDIT = CNT_W'(SYNC_STAGES);

   rst_state_e       state;
   logic [CNT_W-1:0] cnt;

   assign por_hold = (state == POR_HOLD);

   always_ff @(posedge clk) begin
      if (!pwr_good) begin
         state          <= POR_HOLD;
         cnt            <= '0;
         regs_load      <= 1'b1;
         mgmt_ready     <= 1'b0;
         data_clk_valid <= 1'b0;
      end else if (pin_trig && state != POR_HOLD) begin
         state          <= PIN_HOLD;
         cnt            <= '0;
         regs_load      <= 1'b1;
         mgmt_ready     <= 1'b0;
         data_clk_valid <= 1'b0;
      end else if (sw_go) begin
         state          <= MGMT_WAIT;
         cnt            <= '0;
         regs_load      <= 1'b1;
         mgmt_ready     <= 1'b0;
         data_clk_valid <= 1'b0;
      end else begin
         unique case (state)
            POR_HOLD: begin
               if (cnt == POR_END) begin
                  state     <= MGMT_WAIT;
                  cnt       <= '0;
                  regs_load <= 1'b0;
               end else begin
                  cnt       <= cnt + 1'b1;
                  regs_load <= 1'b1;
               end
            end
            PIN_HOLD: begin
               if (pin_high) begin
                  // synchronizer latency already elapsed since release
                  state     <= MGMT_WAIT;
                  cnt       <= PIN_CREDIT;
                  regs_load <= 1'b0;
               end else begin
                  regs_load <= 1'b1;
               end
            end
            MGMT_WAIT: begin
               regs_load <= 1'b0;
               if (cnt == MGMT_END) begin
                  state      <= CLK_WAIT;
                  cnt        <= '0;
                  mgmt_ready <= 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            CLK_WAIT: begin
               regs_load <= 1'b0;
               if (cnt == CLK_END) begin
                  state          <= IDLE_RUN;
                  cnt            <= '0;
                  data_clk_valid <= 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               regs_load <= 1'b0;
               cnt       <= '0;
            end
         endcase
      end
   end

endmodule

// File: rtl/phy_rst_seq.sv
module phy_rst_seq #(
   parameter int SYNC_STAGES = 2,
   parameter int LOW_MIN     = 5,
   parameter int POR_DLY     = 500,
   parameter int MGMT_DLY    = 16,
   parameter int CLK_SETTLE  = 1325000,
   parameter int CTRL_W      = 16,
   parameter int RST_BIT     = 15
) (
   input  logic              clk,
   input  logic              pwr_good,
   input  logic              rst_pin_n,
   input  logic              ctrl_wr,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   output logic              ctrl_rst_rd,
   output logic              regs_load,
   output logic              mgmt_ready,
   output logic              data_clk_valid
);
   generate
      if (SYNC_STAGES < 2)             begin : g_chk_sync  $error("SYNC_STAGES must be at least 2");        end
      if (LOW_MIN < 2)                 begin : g_chk_low   $error("LOW_MIN must be at least 2");            end
      if (MGMT_DLY <= SYNC_STAGES)     begin : g_chk_mgmt  $error("MGMT_DLY must exceed SYNC_STAGES");      end
      if (CLK_SETTLE <= MGMT_DLY)      begin : g_chk_clk   $error("CLK_SETTLE must exceed MGMT_DLY");       end
      if (POR_DLY < 1)                 begin : g_chk_por   $error("POR_DLY must be positive");              end
      if (RST_BIT >= CTRL_W)           begin : g_chk_bit   $error("RST_BIT outside control word");          end
   endgenerate

   logic por_hold;
   logic pin_high;
   logic pin_trig;
   logic sw_go;

   phy_rst_pin_qual #(
      .SYNC_STAGES (SYNC_STAGES),
      .LOW_MIN     (LOW_MIN)
   ) u_pin_qual (
      .clk      (clk),
      .pin_n    (rst_pin_n),
      .isolate  (!pwr_good || por_hold),
      .pin_high (pin_high),
      .trig     (pin_trig)
   );

   phy_rst_ctrl_bit #(
      .CTRL_W  (CTRL_W),
      .RST_BIT (RST_BIT)
   ) u_ctrl_bit (
      .clk        (clk),
      .pwr_good   (pwr_good),
      .wr_allow   (mgmt_ready),
      .ctrl_wr    (ctrl_wr),
      .ctrl_wdata (ctrl_wdata),
      .sw_go      (sw_go),
      .bit_rd     (ctrl_rst_rd)
   );

   phy_rst_seq_fsm #(
      .SYNC_STAGES (SYNC_STAGES),
      .POR_DLY     (POR_DLY),
      .MGMT_DLY    (MGMT_DLY),
      .CLK_SETTLE  (CLK_SETTLE)
   ) u_fsm (
      .clk            (clk),
      .pwr_good       (pwr_good),
      .pin_trig       (pin_trig),
      .pin_high       (pin_high),
      .sw_go          (sw_go),
      .por_hold       (por_hold),
      .regs_load      (regs_load),
      .mgmt_ready     (mgmt_ready),
      .data_clk_valid (data_clk_valid)
   );

endmodule

// File: rtl/phy_rst_seq_chk.sv
module phy_rst_seq_chk (
   input logic clk,
   input logic pwr_good,
   input logic ctrl_wr,
   input logic ctrl_rst_rd,
   input logic regs_load,
   input logic mgmt_ready,
   input logic data_clk_valid
);

   // R12: the edge after supply-good was low leaves the block in reset
   assert_por_forces_R12: assert property (@(posedge clk) disable iff (!pwr_good)
      $past(!pwr_good) |-> (!mgmt_ready && !data_clk_valid && regs_load && !ctrl_rst_rd));

   // R4: data side never valid before the management port
   assert_data_needs_mgmt_R4: assert property (@(posedge clk) disable iff (!pwr_good)
      data_clk_valid |-> mgmt_ready);

   // R10: read-back is one cycle wide
   assert_bit_selfclear_R10: assert property (@(posedge clk) disable iff (!pwr_good)
      ctrl_rst_rd |=> !ctrl_rst_rd);

   // R8: an accepted software write loads defaults and drops readiness
   assert_sw_loads_R8: assert property (@(posedge clk) disable iff (!pwr_good)
      ctrl_rst_rd |-> (regs_load && !mgmt_ready && !data_clk_valid));

   // R11: writes while the port is not ready are ignored
   assert_write_ignored_R11: assert property (@(posedge clk) disable iff (!pwr_good)
      (ctrl_wr && !mgmt_ready) |=> !ctrl_rst_rd);

   // R7: read-back only follows an actual write strobe
   assert_bit_needs_write_R7: assert property (@(posedge clk) disable iff (!pwr_good)
      ctrl_rst_rd |-> $past(ctrl_wr));

endmodule

bind phy_rst_seq phy_rst_seq_chk u_chk (
   .clk            (clk),
   .pwr_good       (pwr_good),
   .ctrl_wr        (ctrl_wr),
   .ctrl_rst_rd    (ctrl_rst_rd),
   .regs_load      (regs_load),
   .mgmt_ready     (mgmt_ready),
   .data_clk_valid (data_clk_valid)
);

// File: tb/phy_rst_seq_bench.sv
`timescale 1ns/1ps
module phy_rst_seq_bench;
   localparam int SYNC = 2;
   localparam int LMIN = 5;
   localparam int PORD = 20;
   localparam int MGMD = 16;
   localparam int SETL = 60;
   localparam int TRIG = SYNC + LMIN - 1;

   logic        clk = 1'b0;
   logic        pwr_good = 1'b0;
   logic        rst_pin_n = 1'b1;
   logic        ctrl_wr = 1'b0;
   logic [15:0] ctrl_wdata = '0;
   logic        ctrl_rst_rd, regs_load, mgmt_ready, data_clk_valid;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   phy_rst_seq #(
      .SYNC_STAGES (SYNC), .LOW_MIN (LMIN), .POR_DLY (PORD),
      .MGMT_DLY (MGMT_DLY_FIX), .CLK_SETTLE (SETL), .CTRL_W (16), .RST_BIT (15)
   ) u_phy_rst_seq (
      .clk (clk), .pwr_good (pwr_good), .rst_pin_n (rst_pin_n),
      .ctrl_wr (ctrl_wr), .ctrl_wdata (ctrl_wdata), .ctrl_rst_rd (ctrl_rst_rd),
      .regs_load (regs_load), .mgmt_ready (mgmt_ready), .data_clk_valid (data_clk_valid)
   );
   localparam int MGMT_DLY_FIX = MGMD;

   task automatic chk(input string req, input string what, input int k, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s k=%0d actual=%b expected=%b", req, what, k, act, exp);
      end
   endtask

   task automatic chk_all(input string req, input int k, input logic m, input logic d,
                          input logic l, input logic r);
      chk(req, "mgmt_ready", k, mgmt_ready, m);
      chk(req, "data_clk_valid", k, data_clk_valid, d);
      chk(req, "regs_load", k, regs_load, l);
      chk(req, "ctrl_rst_rd", k, ctrl_rst_rd, r);
   endtask

   // R12 R10: held in power-on reset while supply-good is low
   task automatic por_low(input int n);
      for (int k = 0; k < n; k++) begin
         pwr_good = 1'b0;
         @(posedge clk); #2;
         chk_all("R12", k, 1'b0, 1'b0, 1'b1, 1'b0);
      end
   endtask

   // R5 R3 R4 R8; with disturb: R6 pin isolated, R11 write ignored
   task automatic por_run(input bit disturb);
      for (int k = 0; k < PORD + SETL + 4; k++) begin
         pwr_good   = 1'b1;
         rst_pin_n  = (disturb && k >= 2 && k < 12) ? 1'b0 : 1'b1;
         ctrl_wr    = disturb && (k == 5);
         ctrl_wdata = 16'h8000;
         @(posedge clk); #2;
         chk_all(disturb ? "R6_R11_R5" : "R5_R3_R4", k,
                 k >= PORD + MGMD, k >= PORD + SETL, k < PORD, 1'b0);
      end
      ctrl_wr = 1'b0;
      rst_pin_n = 1'b1;
   endtask

   // R1 R2 R3 R4 R8 R9 R10: pin pulse of width w, optional second pulse at s
   task automatic pin_run(input int w, input int s);
      int last;
      last = (s > 0) ? s + w + SETL + 3 : w + SETL + 3;
      for (int k = 0; k < last; k++) begin
         logic em, ed, el;
         rst_pin_n = ((k < w) || (s > 0 && k >= s && k < s + w)) ? 1'b0 : 1'b1;
         @(posedge clk); #2;
         em = 1'b1; ed = 1'b1; el = 1'b0;
         if (s > 0 && k >= s + TRIG) begin
            em = (k >= s + w + MGMD);
            ed = (k >= s + w + SETL);
            el = (k < s + w + SYNC);
         end else if (w >= LMIN && k >= TRIG) begin
            em = (k >= w + MGMD);
            ed = (k >= w + SETL);
            el = (k < w + SYNC);
         end
         chk_all((w < LMIN) ? "R2" : ((s > 0) ? "R9_R1" : "R1_R3_R4"), k, em, ed, el, 1'b0);
      end
      rst_pin_n = 1'b1;
   endtask

   // R7 R3 R4 R8 R10 R11 R9: software reset, extra write at index x
   task automatic sw_run(input int x);
      int r;
      r = (x >= MGMD) ? x : 0;
      for (int k = 0; k < r + SETL + 3; k++) begin
         int base;
         ctrl_wr    = (k == 0) || (x > 0 && k == x);
         ctrl_wdata = 16'h8000;
         @(posedge clk); #2;
         base = (k >= r) ? r : 0;
         chk_all((x == 0) ? "R7_R10_R3" : ((r > 0) ? "R9_R7" : "R11"), k,
                 k >= base + MGMD, k >= base + SETL,
                 (k == 0) || (r > 0 && k == r), (k == 0) || (r > 0 && k == r));
      end
      ctrl_wr = 1'b0;
   endtask

   initial begin
      por_low(4);
      por_run(1'b0);
      for (int w = 1; w <= 8; w++) pin_run(w, 0);
      pin_run(6, 30);
      sw_run(0);
      sw_run(8);
      sw_run(40);
      // R7: bit 15 clear does nothing
      for (int k = 0; k < 4; k++) begin
         ctrl_wr    = (k == 0);
         ctrl_wdata = 16'h7FFF;
         @(posedge clk); #2;
         chk_all("R7", k, 1'b1, 1'b1, 1'b0, 1'b0);
      end
      ctrl_wr = 1'b0;
      por_low(3);
      por_run(1'b1);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(100000 * 10);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule